// File: doc/BRIEF.md
# Serial Receiver with Fill-Level Flow Control

This block turns an asynchronous serial line into a stream of characters. It watches the line on a 16x oversampled bit-rate enable that an external divider supplies. It confirms each start bit at mid-bit and captures 5 to 8 data bits, least significant first. It checks an optional parity bit and the first stop bit. Each character is written into a 576-entry buffer together with a parity-error flag and a framing-error flag. The character format is taken from the run-time configuration inputs when the start edge is seen, and it is held for the rest of that character.

Characters leave the buffer through a valid/ready stream. `m_valid` is high whenever the buffer holds a character, and `m_data`, `m_par_err` and `m_frm_err` show the oldest one. An entry is removed on a clock edge where `m_valid` and `m_ready` are both high. While `m_ready` is low the head entry and its flags hold still, so a consumer may apply back-pressure for as long as it needs. The buffer then fills, and the block signals the sender through an active-low request-to-send output driven from the fill level. A character that arrives while the buffer is full is dropped, and a sticky overrun flag is set. An LED output rests high and blinks at about 10 Hz while characters are arriving.

Top module: `uart_rx_flow`

## Requirements
- R1: A character is a low start bit, then 5 + `cfg_bits` data bits (`cfg_bits` 0..3 selects 5..8) least significant first, then an optional parity bit, then a stop bit, each bit 16 ticks long. Data bits above the configured length are delivered as zero.
- R2: The start bit is sampled again at its middle. If the line is high at that sample, the receiver returns to idle and delivers no character.
- R3: `cfg_par` selects the parity bit: 0 none, 1 odd, 2 even, 3 mark (always 1), 4 space (always 0), any other code none. A parity bit that does not match sets `m_par_err` for that character. With no parity the flag is 0.
- R4: A low line at the middle of the stop bit sets `m_frm_err` for that character. The receiver then waits for the line to go high before it looks for the next start bit, so the following character is received correctly.
- R5: The buffer holds 576 characters in arrival order. `m_valid` is high while it is not empty. A character is removed at a clock edge with `m_valid` and `m_ready` high. The head data and flags stay stable while `m_valid` is high and `m_ready` is low.
- R6: A character completed while 576 entries are stored is discarded, even if a read happens in the same cycle, and the stored entries do not change. `overrun` goes high and stays high until reset.
- R7: `rts_n` goes high one cycle after the fill level reaches 383 or more. It goes low one cycle after the fill level falls below 383 minus the hysteresis parameter, which defaults to 0. Otherwise it holds its value.
- R8: `rx_led` is high when the receiver is idle. From the start of a character until the receiver has been idle for `ACT_HALF` cycles, it toggles every `ACT_HALF` cycles. The default of 6,250,000 cycles at 125 MHz gives a 10 Hz blink. Once that idle time has passed, it returns high.
- R9: After reset, `m_valid` is 0, `overrun` is 0, `rts_n` is 0 and `rx_led` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_bits | input | 2 | Data length minus 5 |
| cfg_par | input | 3 | Parity mode code |
| m_valid | output | 1 | Buffer holds a character |
| m_ready | input | 1 | Consumer accepts the head character |
| m_data | output | 8 | Head character data |
| m_par_err | output | 1 | Head character parity error |
| m_frm_err | output | 1 | Head character framing error |
| overrun | output | 1 | Sticky: a character was dropped |
| rts_n | output | 1 | Request to send, active low |
| rx_led | output | 1 | Receive activity indicator |

## Verification
The line passes through a two-stage synchronizer. With `tick_16x` held high, the start-bit check therefore falls about 8.5 cycles after the falling edge, and each later sample falls 16 cycles after the one before. A character enters the buffer at the middle of its stop bit. `m_valid` rises on the next edge, and `rts_n` follows a fill-level change by one more edge. The bench drives the whole stop bit plus one idle bit before it looks at the stream, so every buffered result is already due. It then checks `rts_n` one full cycle after the read that changed the count. All samples are taken on falling clock edges, away from the edge where the design updates.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BREAK
  } rx_state_e;

  typedef struct packed {
    logic       frm_err;
    logic       par_err;
    logic [7:0] data;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

endpackage

// File: rtl/rxf_deser.sv
module rxf_deser
  import rxf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_bits,
  input  logic [2:0] cfg_par,
  output logic       push,
  output rx_word_t   word,
  output logic       busy
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [1:0]    sync_q;
  logic          rxd_s;
  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [2:0]    last_idx;
  logic [2:0]    par_sel;
  logic          has_par;
  logic [7:0]    shreg;
  logic          acc;
  logic          perr;
  logic          par_bad;

  assign rxd_s = sync_q[1];
  assign busy  = (state != S_IDLE);

  always_comb begin
    case (par_sel)
      PAR_ODD:   par_bad = ((acc ^ rxd_s) != 1'b1);
      PAR_EVEN:  par_bad = ((acc ^ rxd_s) != 1'b0);
      PAR_MARK:  par_bad = !rxd_s;
      PAR_SPACE: par_bad = rxd_s;
      default:   par_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
      par_sel  <= PAR_NONE;
      has_par  <= 1'b0;
      shreg    <= '0;
      acc      <= 1'b0;
      perr     <= 1'b0;
      push     <= 1'b0;
      word     <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tick && !rxd_s) begin
            state    <= S_START;
            cnt      <= '0;
            last_idx <= 3'd4 + {1'b0, cfg_bits};
            par_sel  <= cfg_par;
            has_par  <= (cfg_par == PAR_ODD) || (cfg_par == PAR_EVEN) ||
                        (cfg_par == PAR_MARK) || (cfg_par == PAR_SPACE);
            shreg    <= '0;
            perr     <= 1'b0;
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == MID) begin
              cnt     <= '0;
              bit_idx <= '0;
              acc     <= 1'b0;
              state   <= rxd_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt            <= '0;
              shreg[bit_idx] <= rxd_s;
              acc            <= acc ^ rxd_s;
              if (bit_idx == last_idx) state <= has_par ? S_PAR : S_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_PAR: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt   <= '0;
              perr  <= par_bad;
              state <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_STOP: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt   <= '0;
              push  <= 1'b1;
              word  <= '{frm_err: !rxd_s, par_err: perr, data: shreg};
              state <= rxd_s ? S_IDLE : S_BREAK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_BREAK: begin
          if (rxd_s) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: one character yields exactly one single-cycle write
  a_r1_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  // R2: a start bit rejected at mid-bit delivers nothing
  a_r2_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && tick && cnt == MID && rxd_s) |=> (!push && state == S_IDLE));

endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int DEPTH = 576,
  parameter int W     = 10,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  output logic          valid,
  input  logic          ready,
  output logic [W-1:0]  rd_word,
  output logic [CW-1:0] count,
  output logic          overrun
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [PW-1:0] TOP_P  = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, wr_en, rd_en;

  assign full    = (count == FULL_C);
  assign valid   = (count != '0);
  assign wr_en   = push && !full;
  assign rd_en   = valid && ready;
  assign rd_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == TOP_P) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == TOP_P) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) overrun <= 1'b1;
    end
  end

  // R5: an accepted write without a read grows the fill by one
  a_r5_fill_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count != FULL_C && !(valid && ready)) |=> (count == $past(count) + 1'b1));

  // R5: a read without a write shrinks the fill by one
  a_r5_fill_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && valid && ready) |=> (count == $past(count) - 1'b1));

  // R6: a full buffer with no read stays full
  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_C && !ready) |=> (count == FULL_C));

  // R6: overrun is sticky
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: rtl/rxf_activity.sv
module rxf_activity #(
  parameter int ACT_HALF = 6_250_000,
  localparam int HW      = $clog2(ACT_HALF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic led
);

  localparam logic [HW-1:0] HALF_C = HW'(ACT_HALF);
  localparam logic [HW-1:0] WRAP_C = HW'(ACT_HALF - 1);

  logic [HW-1:0] hold, phase;
  logic          active;

  assign active = busy || (hold != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      phase <= '0;
      led   <= 1'b1;
    end else begin
      if (busy)            hold <= HALF_C;
      else if (hold != '0) hold <= hold - 1'b1;

      if (!active) begin
        led   <= 1'b1;
        phase <= '0;
      end else if (phase == WRAP_C) begin
        led   <= ~led;
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R8: the indicator cannot change twice within one half period
  a_r8_no_fast_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (led != $past(led) && busy) |=> $stable(led));

endmodule

// File: rtl/uart_rx_flow.sv
module uart_rx_flow
  import rxf_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DEPTH     = 576,
  parameter int WATERMARK = 383,
  parameter int HYST      = 0,
  parameter int ACT_HALF  = 6_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic       rxd,
  input  logic [1:0] cfg_bits,
  input  logic [2:0] cfg_par,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_par_err,
  output logic       m_frm_err,
  output logic       overrun,
  output logic       rts_n,
  output logic       rx_led
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(WATERMARK);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(WATERMARK - HYST);

  logic             push;
  rx_word_t         push_word;
  rx_word_t         head;
  logic [WORD_W-1:0] head_bits;
  logic             busy;
  logic [CNT_W-1:0] fill;

  rxf_deser #(.OSR(OSR)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_16x),
    .rxd      (rxd),
    .cfg_bits (cfg_bits),
    .cfg_par  (cfg_par),
    .push     (push),
    .word     (push_word),
    .busy     (busy)
  );

  rxf_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word (push_word),
    .valid     (m_valid),
    .ready     (m_ready),
    .rd_word   (head_bits),
    .count     (fill),
    .overrun   (overrun)
  );

  rxf_activity #(.ACT_HALF(ACT_HALF)) u_act (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .led   (rx_led)
  );

  assign head      = head_bits;
  assign m_data    = head.data;
  assign m_par_err = head.par_err;
  assign m_frm_err = head.frm_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rts_n <= 1'b0;
    else if (fill >= HIGH_C) rts_n <= 1'b1;
    else if (fill < LOW_C)   rts_n <= 1'b0;
  end

  // R7: at or above the watermark the sender is told to stop
  a_r7_rts_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill >= HIGH_C) |=> rts_n);

  // R7: below the low mark the sender is released
  a_r7_rts_go: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < LOW_C) |=> !rts_n);

  // R5: head entry holds still under back-pressure
  a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_par_err)
                               && $stable(m_frm_err)));

endmodule

// File: tb/uart_rx_flow_bench.sv
module uart_rx_flow_bench;

  localparam int BIT_CYC = 16;
  localparam int HALF    = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd;
  logic [1:0] cfg_bits;
  logic [2:0] cfg_par;
  logic       m_valid, m_ready;
  logic [7:0] m_data;
  logic       m_par_err, m_frm_err, overrun, rts_n, rx_led;

  int vectors = 0;
  int fails   = 0;
  int led_edges = 0;
  logic led_prev = 1'b1;

  always #4 clk = ~clk;

  uart_rx_flow #(.ACT_HALF(HALF)) u_uart_rx_flow (
    .clk(clk), .rst_n(rst_n), .tick_16x(1'b1), .rxd(rxd),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_par_err(m_par_err), .m_frm_err(m_frm_err),
    .overrun(overrun), .rts_n(rts_n), .rx_led(rx_led)
  );

  always @(negedge clk) begin
    if (rx_led !== led_prev) led_edges++;
    led_prev <= rx_led;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input int nb, input int par);
    logic ones;
    ones = ^exp_data(d, nb);
    case (par)
      1: return ~ones;
      2: return ones;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive_bit(input logic b, input int cyc);
    rxd = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int nb, input int par,
                           input bit bad_par, input bit bad_stop);
    cfg_bits = 2'(nb - 5);
    cfg_par  = 3'(par);
    drive_bit(1'b0, BIT_CYC);
    for (int i = 0; i < nb; i++) drive_bit(d[i], BIT_CYC);
    if (par >= 1 && par <= 4) drive_bit(par_bit(d, nb, par) ^ bad_par, BIT_CYC);
    drive_bit(!bad_stop, BIT_CYC);
    drive_bit(1'b1, BIT_CYC);
  endtask

  task automatic read_one(input string req, input logic [7:0] ed, input logic ep, input logic ef);
    chk(req, 32'(m_valid), 32'd1);
    chk(req, 32'(m_data), 32'(ed));
    chk(req, 32'(m_par_err), 32'(ep));
    chk(req, 32'(m_frm_err), 32'(ef));
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int e0;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; rxd = 1'b1; m_ready = 1'b0; cfg_bits = 2'd3; cfg_par = 3'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 valid", 32'(m_valid), 0);
    chk("R9 overrun", 32'(overrun), 0);
    chk("R9 rts_n", 32'(rts_n), 0);
    chk("R9 led", 32'(rx_led), 1);

    // R1 8-bit and 5-bit framing, upper bits zero
    send_char(8'hA5, 8, 0, 0, 0);
    read_one("R1 8bit", 8'hA5, 0, 0);
    send_char(8'hFF, 5, 0, 0, 0);
    read_one("R1 5bit upper zero", 8'h1F, 0, 0);
    send_char(8'h6B, 7, 0, 0, 0);
    // R5 head held under back-pressure
    repeat (5) @(negedge clk);
    chk("R5 hold", 32'(m_data), 32'h6B);
    read_one("R1 7bit", 8'h6B, 0, 0);

    // R3 each parity mode, good and bad
    for (int p = 1; p <= 4; p++) begin
      send_char(8'h3C, 8, p, 0, 0);
      read_one("R3 parity good", 8'h3C, 0, 0);
      send_char(8'h2D, 6, p, 1, 0);
      read_one("R3 parity bad", 8'h2D, 1, 0);
    end

    // R4 framing error then clean recovery
    send_char(8'h55, 8, 2, 0, 1);
    read_one("R4 frame err", 8'h55, 0, 1);
    send_char(8'h81, 8, 0, 0, 0);
    read_one("R4 recovery", 8'h81, 0, 0);

    // R2 short glitch yields nothing
    drive_bit(1'b0, 3);
    drive_bit(1'b1, 4 * BIT_CYC);
    chk("R2 glitch", 32'(m_valid), 0);

    // R8 activity blink and return to idle high
    repeat (3 * HALF) @(negedge clk);
    chk("R8 idle high", 32'(rx_led), 1);
    e0 = led_edges;
    send_char(8'h99, 8, 1, 0, 0);
    chk("R8 toggles", 32'(led_edges - e0 >= 2), 1);
    read_one("R8 char", 8'h99, 0, 0);
    repeat (3 * HALF) @(negedge clk);
    chk("R8 back high", 32'(rx_led), 1);

    // R1 R3 R4 random formats and errors
    for (int k = 0; k < 60; k++) begin
      logic [7:0] d;
      int nb, par;
      bit bp, bs;
      d   = 8'($urandom);
      nb  = 5 + int'($urandom % 4);
      par = int'($urandom % 6);
      bp  = (par >= 1 && par <= 4) && ($urandom % 4 == 0);
      bs  = ($urandom % 5 == 0);
      send_char(d, nb, par, bp, bs);
      read_one("R1/R3/R4 random", exp_data(d, nb), bp, bs);
    end

    // R5 order
    send_char(8'h11, 8, 0, 0, 0);
    send_char(8'h22, 8, 0, 0, 0);
    send_char(8'h33, 8, 0, 0, 0);
    read_one("R5 order", 8'h11, 0, 0);
    read_one("R5 order", 8'h22, 0, 0);
    read_one("R5 order", 8'h33, 0, 0);
    chk("R5 empty", 32'(m_valid), 0);

    // R7 watermark, R6 full and overrun
    for (int i = 0; i < 382; i++) send_char(8'(i) ^ 8'h15, 5, 0, 0, 0);
    chk("R7 below mark", 32'(rts_n), 0);
    send_char(8'(382) ^ 8'h15, 5, 0, 0, 0);
    chk("R7 at mark", 32'(rts_n), 1);
    for (int i = 383; i < 576; i++) send_char(8'(i) ^ 8'h15, 5, 0, 0, 0);
    chk("R6 no overrun yet", 32'(overrun), 0);
    send_char(8'h0A, 5, 0, 0, 0);
    send_char(8'h0B, 5, 0, 0, 0);
    chk("R6 overrun", 32'(overrun), 1);
    for (int i = 0; i < 576; i++) begin
      read_one("R6 drain", exp_data(8'(i) ^ 8'h15, 5), 0, 0);
      @(negedge clk);
      if (i == 192) chk("R7 still high", 32'(rts_n), 1);
      if (i == 193) chk("R7 released", 32'(rts_n), 0);
    end
    chk("R6 empty after drain", 32'(m_valid), 0);
    chk("R6 sticky", 32'(overrun), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule